// File: doc/BRIEF.md
# UART FIFO Interrupt-Level and Receive Watchdog Controller

This block derives the two interrupt requests of one UART channel from the occupancy of its FIFOs. The receive side compares the number of stored bytes in an 8-deep receive FIFO against a programmable fill level. The transmit side compares the number of free positions in an 8-deep transmit FIFO against a programmable vacancy level. The FIFO storage and the serial shifters sit outside; this block only sees their counts and access strobes.

A receive watchdog covers the tail of a message that is too short to reach the fill level. It counts bit-time ticks while the receive FIFO holds data and nobody touches it. After 64 idle bit times it latches a flag, and that flag forces the receive request. Software then reads the FIFO, which clears the flag.

The receive level code is assembled from two separate mode fields. A single bit supplies the top bit and a two-bit field supplies the lower bits. The requests are combinational in the counts, so they follow the FIFO in the same cycle.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset, with `rx_count`=0, `tx_enable`=0 and `rx_wd_enable`=0, `rx_irq`, `tx_irq` and `rx_wd_flag` are all 0.
- R2: The receive level code is {`rx_lvl_msb`, `rx_lvl_lsbs`[1:0]}, with `rx_lvl_msb` as bit 2. Code n (0..7) makes `rx_irq`=1 in the same cycle whenever `rx_count` >= n+1, and the threshold term is 0 when `rx_count` <= n.
- R3: The transmit level code `tx_lvl` selects the needed free positions: 00 -> 8 (FIFO completely empty), 01 -> 4 or more, 10 -> 6 or more, 11 -> 1 or more. `tx_irq` follows `tx_free` in the same cycle.
- R4: `tx_irq` is 0 whenever `tx_enable`=0. With code 00 and `tx_free`=8, it rises in the same cycle that `tx_enable` goes to 1, and it drops as soon as `tx_free` falls to 7.
- R5: With `rx_wd_enable`=0, `rx_wd_flag` never sets, however many ticks pass while data is waiting.
- R6: With `rx_wd_enable`=1 and `rx_count`>0, `rx_wd_flag` sets at the clock edge that samples the 64th `bit_tick` pulse since the last access. After 63 pulses it is still 0.
- R7: A pulse on `rx_read` or `rx_write` restarts the idle count, so a full 64 further tick pulses are needed before the flag sets.
- R8: While `rx_count`=0 the idle count is held at zero and the flag cannot set. Counting starts fresh once data appears.
- R9: `rx_wd_flag` stays set until the clock edge that samples `rx_read`=1, and while set it drives `rx_irq`=1 even when the fill level is not reached.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle pulse per receiver bit time |
| rx_count | input | 4 | Bytes held in the receive FIFO (0..8) |
| tx_free | input | 4 | Free positions in the transmit FIFO (0..8) |
| rx_read | input | 1 | Receive FIFO read strobe |
| rx_write | input | 1 | Receive FIFO write strobe |
| tx_enable | input | 1 | Transmitter enabled |
| rx_wd_enable | input | 1 | Receive watchdog enable |
| rx_lvl_msb | input | 1 | Bit 2 of the receive level code |
| rx_lvl_lsbs | input | 2 | Bits 1:0 of the receive level code |
| tx_lvl | input | 2 | Transmit level code |
| rx_irq | output | 1 | Receive interrupt request |
| tx_irq | output | 1 | Transmit interrupt request |
| rx_wd_flag | output | 1 | Latched watchdog timeout flag |

## Verification
The hardest situation to reach from the ports is the exact edge of the 64-tick idle window. Here the flag must still be clear after 63 pulses and set after the 64th, and a strobe in the middle must push the edge back by a full window. The stimulus sets the receive level to 8, so the threshold term cannot hide the flag. It pulses `rx_write` to start from a known zero, then issues an exact number of one-cycle `bit_tick` pulses and samples the flag between pulses. The same counting is repeated with an access strobe part-way through, with an empty FIFO, and with the watchdog disabled.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  parameter int unsigned FIFO_DEPTH = 8;
  parameter int unsigned WD_BIT_TIMES = 64;
  localparam int unsigned CNT_W = $clog2(FIFO_DEPTH + 1);

  typedef enum logic [1:0] {
    TXL_ALL     = 2'b00,
    TXL_HALF    = 2'b01,
    TXL_3QUART  = 2'b10,
    TXL_ANY     = 2'b11
  } tx_lvl_e;
endpackage

// File: rtl/uart_rx_level.sv
module uart_rx_level
  import uart_irq_pkg::*;
#(
  parameter int unsigned CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] count,
  input  logic [2:0]    code,
  output logic          hit
);
  logic [CW-1:0] need;

  always_comb begin
    need = CW'(code) + CW'(1);
    hit  = (count >= need);
  end

  AST_FULL_HITS: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CW'(FIFO_DEPTH)) |-> hit); // R2
  AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0) |-> !hit); // R2
endmodule

// File: rtl/uart_tx_level.sv
module uart_tx_level
  import uart_irq_pkg::*;
#(
  parameter int unsigned CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] free,
  input  logic [1:0]    code,
  input  logic          enable,
  output logic          req
);
  localparam logic [CW-1:0] NEED_ALL  = CW'(FIFO_DEPTH);
  localparam logic [CW-1:0] NEED_HALF = CW'(FIFO_DEPTH / 2);
  localparam logic [CW-1:0] NEED_3Q   = CW'((FIFO_DEPTH * 3) / 4);
  localparam logic [CW-1:0] NEED_ANY  = CW'(1);

  logic [CW-1:0] need;

  always_comb begin
    unique case (tx_lvl_e'(code))
      TXL_ALL:    need = NEED_ALL;
      TXL_HALF:   need = NEED_HALF;
      TXL_3QUART: need = NEED_3Q;
      default:    need = NEED_ANY;
    endcase
    req = enable && (free >= need);
  end

  AST_TX_FULL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (free == '0) |-> !req); // R3
  AST_TX_EMPTY_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && free == NEED_ALL) |-> req); // R4
endmodule

// File: rtl/uart_rx_watchdog.sv
module uart_rx_watchdog
  import uart_irq_pkg::*;
#(
  parameter int unsigned LIMIT = WD_BIT_TIMES,
  parameter int unsigned CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          tick,
  input  logic          rd,
  input  logic          wr,
  input  logic [CW-1:0] count,
  output logic          flag
);
  localparam int unsigned WDW = $clog2(LIMIT) + 1;
  localparam logic [WDW-1:0] LAST = WDW'(LIMIT - 1);
  localparam logic [WDW-1:0] SAT  = WDW'(LIMIT);

  logic [WDW-1:0] idle_q, idle_d;
  logic           idle_en;
  logic           flag_d, flag_en;
  logic           restart, fire;

  always_comb begin
    restart = rd || wr || (count == '0) || !enable;
    fire    = !restart && tick && (idle_q == LAST);
    idle_en = restart || (tick && (idle_q != SAT));
    idle_d  = restart ? '0 : idle_q + WDW'(1);
    flag_en = rd || fire;
    flag_d  = !rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       idle_q <= '0;
    else if (idle_en) idle_q <= idle_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag <= 1'b0;
    else if (flag_en) flag <= flag_d;
  end

  AST_IDLE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    idle_q <= SAT); // R6
  AST_ACCESS_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (rd || wr) |=> (idle_q == '0)); // R7
  AST_NO_FIRE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0 && !flag) |=> !flag); // R8
  AST_OFF_NO_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !flag) |=> !flag); // R5
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> !flag); // R9
  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !rd) |=> flag); // R9
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_tick,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [CNT_W-1:0] tx_free,
  input  logic             rx_read,
  input  logic             rx_write,
  input  logic             tx_enable,
  input  logic             rx_wd_enable,
  input  logic             rx_lvl_msb,
  input  logic [1:0]       rx_lvl_lsbs,
  input  logic [1:0]       tx_lvl,
  output logic             rx_irq,
  output logic             tx_irq,
  output logic             rx_wd_flag
);
  logic [2:0] rx_code;
  logic       rx_hit;

  assign rx_code = {rx_lvl_msb, rx_lvl_lsbs};

  uart_rx_level #(.CW(CNT_W)) u_rx_level (
    .clk(clk), .rst_n(rst_n), .count(rx_count), .code(rx_code), .hit(rx_hit)
  );

  uart_tx_level #(.CW(CNT_W)) u_tx_level (
    .clk(clk), .rst_n(rst_n), .free(tx_free), .code(tx_lvl),
    .enable(tx_enable), .req(tx_irq)
  );

  uart_rx_watchdog #(.LIMIT(WD_BIT_TIMES), .CW(CNT_W)) u_rx_wd (
    .clk(clk), .rst_n(rst_n), .enable(rx_wd_enable), .tick(bit_tick),
    .rd(rx_read), .wr(rx_write), .count(rx_count), .flag(rx_wd_flag)
  );

  always_comb rx_irq = rx_hit || rx_wd_flag;

  AST_TX_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_enable |-> !tx_irq); // R4
  AST_WD_FORCES_RX: assert property (@(posedge clk) disable iff (!rst_n)
    rx_wd_flag |-> rx_irq); // R9
endmodule

// File: tb/test_uart_irq_ctrl.sv
module test_uart_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       bit_tick, rx_read, rx_write, tx_enable, rx_wd_enable, rx_lvl_msb;
  logic [3:0] rx_count, tx_free;
  logic [1:0] rx_lvl_lsbs, tx_lvl;
  logic       rx_irq, tx_irq, rx_wd_flag;
  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  uart_irq_ctrl i_uart_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .rx_count(rx_count),
    .tx_free(tx_free), .rx_read(rx_read), .rx_write(rx_write),
    .tx_enable(tx_enable), .rx_wd_enable(rx_wd_enable), .rx_lvl_msb(rx_lvl_msb),
    .rx_lvl_lsbs(rx_lvl_lsbs), .tx_lvl(tx_lvl), .rx_irq(rx_irq),
    .tx_irq(tx_irq), .rx_wd_flag(rx_wd_flag)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      bit_tick = 1'b1; step(); bit_tick = 1'b0;
    end
  endtask

  task automatic strobe_wr();
    rx_write = 1'b1; step(); rx_write = 1'b0;
  endtask

  task automatic strobe_rd();
    rx_read = 1'b1; step(); rx_read = 1'b0;
  endtask

  task automatic set_rx_code(input int c);
    rx_lvl_msb  = c[2];
    rx_lvl_lsbs = c[1:0];
  endtask

  task automatic t_reset();
    chk("R1 rx_irq", rx_irq, 0);
    chk("R1 tx_irq", tx_irq, 0);
    chk("R1 rx_wd_flag", rx_wd_flag, 0);
  endtask

  task automatic t_rx_levels();
    rx_wd_enable = 1'b0;
    for (int c = 0; c < 8; c++) begin
      set_rx_code(c);
      rx_count = 4'(c + 1); #1;
      chk("R2 at level", rx_irq, 1);
      rx_count = 4'(c); #1;
      chk("R2 below level", rx_irq, 0);
    end
    rx_count = 4'd0;
  endtask

  task automatic t_tx_levels();
    int need [4] = '{8, 4, 6, 1};
    tx_enable = 1'b1;
    for (int c = 0; c < 4; c++) begin
      tx_lvl = 2'(c);
      tx_free = 4'(need[c]); #1;
      chk("R3 at level", tx_irq, 1);
      tx_free = 4'(need[c] - 1); #1;
      chk("R3 below level", tx_irq, 0);
    end
  endtask

  task automatic t_tx_enable();
    tx_lvl = 2'b00; tx_free = 4'd8; tx_enable = 1'b0; #1;
    chk("R4 disabled", tx_irq, 0);
    tx_enable = 1'b1; #1;
    chk("R4 enable raises", tx_irq, 1);
    tx_free = 4'd7; #1;
    chk("R4 one byte loaded", tx_irq, 0);
    tx_enable = 1'b0; tx_free = 4'd8; #1;
  endtask

  task automatic t_wd_fire();
    set_rx_code(7); rx_wd_enable = 1'b1; rx_count = 4'd1;
    strobe_wr();
    ticks(63);
    chk("R6 after 63 ticks", rx_wd_flag, 0);
    chk("R6 rx_irq after 63", rx_irq, 0);
    ticks(1);
    chk("R6 after 64 ticks", rx_wd_flag, 1);
    chk("R9 flag forces rx_irq", rx_irq, 1);
    ticks(10);
    chk("R9 flag latched", rx_wd_flag, 1);
    rx_count = 4'd0;
    strobe_rd();
    chk("R9 read clears", rx_wd_flag, 0);
    chk("R9 rx_irq cleared", rx_irq, 0);
  endtask

  task automatic t_wd_restart();
    rx_count = 4'd2;
    strobe_wr();
    ticks(40);
    strobe_wr();
    ticks(40);
    chk("R7 restarted window", rx_wd_flag, 0);
    ticks(23);
    chk("R7 63 after restart", rx_wd_flag, 0);
    ticks(1);
    chk("R7 64 after restart", rx_wd_flag, 1);
    rx_count = 4'd1;
    strobe_rd();
    chk("R9 read clears again", rx_wd_flag, 0);
  endtask

  task automatic t_wd_empty();
    rx_count = 4'd0;
    strobe_rd();
    ticks(100);
    chk("R8 empty no fire", rx_wd_flag, 0);
    rx_count = 4'd1;
    ticks(63);
    chk("R8 fresh count 63", rx_wd_flag, 0);
    ticks(1);
    chk("R8 fresh count 64", rx_wd_flag, 1);
    rx_count = 4'd0;
    strobe_rd();
  endtask

  task automatic t_wd_off();
    rx_wd_enable = 1'b0; rx_count = 4'd1;
    strobe_wr();
    ticks(100);
    chk("R5 disabled no flag", rx_wd_flag, 0);
    chk("R5 rx_irq low", rx_irq, 0);
    rx_count = 4'd0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bit_tick = 1'b0; rx_read = 1'b0; rx_write = 1'b0;
    tx_enable = 1'b0; rx_wd_enable = 1'b0; rx_lvl_msb = 1'b0;
    rx_lvl_lsbs = 2'b00; tx_lvl = 2'b00; rx_count = 4'd0; tx_free = 4'd8;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step();
    t_reset();
    t_rx_levels();
    t_tx_levels();
    t_tx_enable();
    t_wd_fire();
    t_wd_restart();
    t_wd_empty();
    t_wd_off();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule